// File: doc/BRIEF.md
# UF8 Logarithmic Integer Codec

This block converts between 32-bit unsigned integers and a one-byte logarithmic code. The code byte holds an exponent in its upper nibble and a mantissa in its lower nibble. Exponent `e` selects a bucket that starts at base `16*(2^e - 1)`. Inside the bucket the mantissa counts steps of `2^e`. Small integers keep their exact value. Large integers lose their low-order bits.

The encoder finds the most significant set bit with a leading-zero count and derives a first exponent guess from it. It then corrects that guess by one bucket, either down or up, against the bucket bases, and extracts the mantissa. The decoder rebuilds the bucket base from the exponent and adds the scaled mantissa.

The encode path and the decode path are independent. Each has its own valid strobe. A parameter chooses between two variants: a registered output stage with one cycle of latency, or a purely combinational pass-through. The register stage holds its data while no new request arrives.

Top module: `uf8_codec`

## Requirements
- R1: An encode input below 16 produces a code byte equal to the input (exponent 0, mantissa = value).
- R2: The encoded exponent (bits 7:4) is the largest e in 0..15 for which `16*(2^e - 1)` is less than or equal to the input; any input of 16 or more gives a non-zero exponent.
- R3: The encoded mantissa (bits 3:0) is `((value - 16*(2^e - 1)) >> e) mod 16`, and the code byte is `(e << 4) | mantissa`.
- R4: Inputs at or above 0x7FFF0 give exponent 15 and the mantissa field wraps modulo 16 with no saturation (0x000FFFFF gives 0xF0, 0x00123456 gives 0xF4, 0xFFFFFFFF gives 0xF0).
- R5: Decoding a code byte with exponent e (bits 7:4) and mantissa m (bits 3:0) gives `(m << e) + 16*(2^e - 1)`; an exponent of 0 gives m.
- R6: For every one of the 256 code bytes, encoding the decoded value returns the same code byte.
- R7: With the registered variant, each output valid is asserted exactly one cycle after its input valid, and the encode and decode paths do not affect each other.
- R8: With the registered variant, a cycle with an input valid low leaves that path's output data unchanged and drives its output valid low.
- R9: Synchronous active-high reset clears both output valids and both output data words to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_valid_i | input | 1 | Encode request strobe |
| enc_value_i | input | 32 | Integer to encode |
| dec_valid_i | input | 1 | Decode request strobe |
| dec_code_i | input | 8 | Code byte to decode |
| enc_valid_o | output | 1 | Encode result strobe |
| enc_code_o | output | 8 | Encoded byte, exponent in 7:4, mantissa in 3:0 |
| dec_valid_o | output | 1 | Decode result strobe |
| dec_value_o | output | 32 | Decoded integer |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the one-cycle strobe timing of each path and data holding in idle cycles;
- pass-through of values below 16;
- a non-zero exponent for every input of 16 or more;
- exponent 15 for every input at or above the top bucket base;
- decoding of exponent-0 codes to their mantissa.

Other behaviours can only be shown by the bench's scenarios:
- the exact exponent and mantissa for each bucket, including the values on either side of every bucket base;
- the wrapped mantissa of oversized inputs;
- the round trip over all 256 codes;
- clearing by reset in the middle of activity.

// File: rtl/uf8_pkg.sv
package uf8_pkg;

    localparam int VALUE_W = 32;
    localparam int EXP_W   = 4;
    localparam int MAN_W   = 4;
    localparam int CODE_W  = EXP_W + MAN_W;
    localparam int LZ_W    = $clog2(VALUE_W) + 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;
    // first exponent guess is msb - MAN_W; below this msb the guess is zero
    localparam int EST_MIN_MSB = MAN_W + 1;

    typedef logic [VALUE_W-1:0] value_t;
    typedef logic [EXP_W-1:0]   exp_t;
    typedef logic [MAN_W-1:0]   man_t;
    typedef logic [LZ_W-1:0]    lz_t;
    typedef logic [EXP_W:0]     exp_wide_t;

    typedef struct packed {
        exp_t exp;
        man_t man;
    } code_t;

    localparam value_t SMALL_LIMIT = value_t'(1) << MAN_W;
    localparam value_t BASE_FULL   = (value_t'(1) << EXP_MAX) - value_t'(1);

    // start of the bucket for exponent e: ((2^e) - 1) scaled by 2^MAN_W
    function automatic value_t bucket_base(input exp_wide_t e);
        return ((value_t'(1) << e) - value_t'(1)) << MAN_W;
    endfunction

endpackage

// File: rtl/uf8_lzc.sv
module uf8_lzc
    import uf8_pkg::*;
(
    input  value_t word_i,
    output lz_t    count_o
);

    // a set bit at position i leaves VALUE_W-1-i leading zeros; the highest set bit wins
    always_comb begin
        count_o = lz_t'(VALUE_W);
        for (int i = 0; i < VALUE_W; i++) begin
            if (word_i[i]) begin
                count_o = lz_t'(VALUE_W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/uf8_encoder.sv
module uf8_encoder
    import uf8_pkg::*;
(
    input  value_t value_i,
    output code_t  code_o
);

    lz_t       lead_zeros;
    lz_t       msb_pos;
    exp_t      exp_guess;
    exp_t      exp_low;
    exp_t      exp_final;
    value_t    base_guess;
    value_t    base_next;
    value_t    residue;
    value_t    scaled;

    uf8_lzc u_lzc (
        .word_i  (value_i),
        .count_o (lead_zeros)
    );

    // an all-zero word yields no meaningful msb; the small-value path covers it
    assign msb_pos = lz_t'(VALUE_W - 1) - lead_zeros;

    // step 1: guess from the msb position, clamped to the exponent range
    always_comb begin
        if (msb_pos < lz_t'(EST_MIN_MSB)) begin
            exp_guess = '0;
        end else if ((msb_pos - lz_t'(MAN_W)) > lz_t'(EXP_MAX)) begin
            exp_guess = exp_t'(EXP_MAX);
        end else begin
            exp_guess = exp_t'(msb_pos - lz_t'(MAN_W));
        end
    end

    // step 2: drop one bucket if the value lies below the guessed base
    assign base_guess = bucket_base(exp_wide_t'(exp_guess));

    always_comb begin
        if ((exp_guess != '0) && (value_i < base_guess)) begin
            exp_low = exp_guess - exp_t'(1);
        end else begin
            exp_low = exp_guess;
        end
    end

    // step 3: climb one bucket if the value reaches the next base
    assign base_next = bucket_base(exp_wide_t'(exp_low) + exp_wide_t'(1));

    always_comb begin
        if ((exp_low != exp_t'(EXP_MAX)) && (value_i >= base_next)) begin
            exp_final = exp_low + exp_t'(1);
        end else begin
            exp_final = exp_low;
        end
    end

    assign residue = value_i - bucket_base(exp_wide_t'(exp_final));
    assign scaled  = residue >> exp_final;

    always_comb begin
        if (value_i < SMALL_LIMIT) begin
            code_o = code_t'(value_i[CODE_W-1:0]);
        end else begin
            code_o.exp = exp_final;
            code_o.man = scaled[MAN_W-1:0];
        end
    end

endmodule

// File: rtl/uf8_decoder.sv
module uf8_decoder
    import uf8_pkg::*;
(
    input  code_t  code_i,
    output value_t value_o
);

    value_t base;
    value_t step;

    // bucket start from a right-shifted mask of EXP_MAX ones
    assign base    = (BASE_FULL >> (exp_t'(EXP_MAX) - code_i.exp)) << MAN_W;
    assign step    = value_t'(code_i.man) << code_i.exp;
    assign value_o = step + base;

endmodule

// File: rtl/uf8_codec.sv
module uf8_codec
    import uf8_pkg::*;
#(
    parameter bit PIPE = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        enc_valid_i,
    input  logic [uf8_pkg::VALUE_W-1:0] enc_value_i,
    input  logic                        dec_valid_i,
    input  logic [uf8_pkg::CODE_W-1:0]  dec_code_i,
    output logic                        enc_valid_o,
    output logic [uf8_pkg::CODE_W-1:0]  enc_code_o,
    output logic                        dec_valid_o,
    output logic [uf8_pkg::VALUE_W-1:0] dec_value_o
);

    code_t  enc_code_c;
    value_t dec_value_c;

    uf8_encoder u_enc (
        .value_i (enc_value_i),
        .code_o  (enc_code_c)
    );

    uf8_decoder u_dec (
        .code_i  (code_t'(dec_code_i)),
        .value_o (dec_value_c)
    );

    generate
        if (PIPE) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    enc_valid_o <= 1'b0;
                    enc_code_o  <= '0;
                    dec_valid_o <= 1'b0;
                    dec_value_o <= '0;
                end else begin
                    enc_valid_o <= enc_valid_i;
                    dec_valid_o <= dec_valid_i;
                    if (enc_valid_i) begin
                        enc_code_o <= enc_code_c;
                    end
                    if (dec_valid_i) begin
                        dec_value_o <= dec_value_c;
                    end
                end
            end
        end else begin : g_comb
            assign enc_valid_o = enc_valid_i;
            assign enc_code_o  = enc_code_c;
            assign dec_valid_o = dec_valid_i;
            assign dec_value_o = dec_value_c;
        end
    endgenerate

endmodule

// File: rtl/uf8_codec_checker.sv
module uf8_codec_checker
    import uf8_pkg::*;
#(
    parameter bit PIPE = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic                enc_valid_i,
    input logic [VALUE_W-1:0]  enc_value_i,
    input logic                dec_valid_i,
    input logic [CODE_W-1:0]   dec_code_i,
    input logic                enc_valid_o,
    input logic [CODE_W-1:0]   enc_code_o,
    input logic                dec_valid_o,
    input logic [VALUE_W-1:0]  dec_value_o
);

    localparam value_t TOP_BASE = bucket_base(exp_wide_t'(EXP_MAX));

    generate
        if (PIPE) begin : g_pipe_checks
            p_enc_latency_r7: assert property (@(posedge clk) disable iff (rst)
                enc_valid_i |=> enc_valid_o);
            p_dec_latency_r7: assert property (@(posedge clk) disable iff (rst)
                dec_valid_i |=> dec_valid_o);
            p_enc_hold_r8: assert property (@(posedge clk) disable iff (rst)
                !enc_valid_i |=> (!enc_valid_o && $stable(enc_code_o)));
            p_dec_hold_r8: assert property (@(posedge clk) disable iff (rst)
                !dec_valid_i |=> (!dec_valid_o && $stable(dec_value_o)));
            p_small_pass_r1: assert property (@(posedge clk) disable iff (rst)
                (enc_valid_o && ($past(enc_value_i) < SMALL_LIMIT))
                    |-> (VALUE_W'(enc_code_o) == $past(enc_value_i)));
            p_nonzero_exp_r2: assert property (@(posedge clk) disable iff (rst)
                (enc_valid_o && ($past(enc_value_i) >= SMALL_LIMIT))
                    |-> (enc_code_o[CODE_W-1:MAN_W] != '0));
            p_top_bucket_r4: assert property (@(posedge clk) disable iff (rst)
                (enc_valid_o && ($past(enc_value_i) >= TOP_BASE))
                    |-> (enc_code_o[CODE_W-1:MAN_W] == exp_t'(EXP_MAX)));
            p_exp0_decode_r5: assert property (@(posedge clk) disable iff (rst)
                (dec_valid_o && ($past(dec_code_i[CODE_W-1:MAN_W]) == '0))
                    |-> (dec_value_o == VALUE_W'($past(dec_code_i[MAN_W-1:0]))));
        end
    endgenerate

endmodule

bind uf8_codec uf8_codec_checker #(.PIPE(PIPE)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .enc_valid_i (enc_valid_i),
    .enc_value_i (enc_value_i),
    .dec_valid_i (dec_valid_i),
    .dec_code_i  (dec_code_i),
    .enc_valid_o (enc_valid_o),
    .enc_code_o  (enc_code_o),
    .dec_valid_o (dec_valid_o),
    .dec_value_o (dec_value_o)
);

// File: tb/uf8_codec_test.sv
`timescale 1ns/1ps
module uf8_codec_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_valid_i = 1'b0;
    logic [31:0] enc_value_i = '0;
    logic        dec_valid_i = 1'b0;
    logic [7:0]  dec_code_i = '0;
    logic        enc_valid_o;
    logic [7:0]  enc_code_o;
    logic        dec_valid_o;
    logic [31:0] dec_value_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    uf8_codec uut (
        .clk         (clk),
        .rst         (rst),
        .enc_valid_i (enc_valid_i),
        .enc_value_i (enc_value_i),
        .dec_valid_i (dec_valid_i),
        .dec_code_i  (dec_code_i),
        .enc_valid_o (enc_valid_o),
        .enc_code_o  (enc_code_o),
        .dec_valid_o (dec_valid_o),
        .dec_value_o (dec_value_o)
    );

    function automatic longint base_of(int e);
        return ((longint'(1) << e) - 1) * 16;
    endfunction

    function automatic logic [7:0] ref_enc(logic [31:0] v);
        int e = 0;
        longint m;
        if (v < 32'd16) return v[7:0];
        for (int k = 1; k < 16; k++) begin
            if (longint'(v) >= base_of(k)) e = k;
        end
        m = ((longint'(v) - base_of(e)) >> e) & 15;
        return {4'(e), 4'(m)};
    endfunction

    function automatic logic [31:0] ref_dec(logic [7:0] c);
        int e = int'(c[7:4]);
        return 32'((longint'(c[3:0]) << e) + base_of(e));
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive both paths, wait one cycle, compare registered results
    task automatic run_pair(logic [31:0] v, logic [7:0] c, string tag);
        enc_valid_i = 1'b1;
        enc_value_i = v;
        dec_valid_i = 1'b1;
        dec_code_i  = c;
        @(negedge clk);
        check({tag, " enc"}, {24'd0, enc_code_o}, {24'd0, ref_enc(v)});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  held;
        logic [31:0] held_v;
        r = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 enc_valid", {31'd0, enc_valid_o}, 32'd0);
        check("R9 enc_code", {24'd0, enc_code_o}, 32'd0);
        check("R9 dec_valid", {31'd0, dec_valid_o}, 32'd0);
        check("R9 dec_value", dec_value_o, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1 and R2/R3: exhaustive low range
        for (int v = 0; v < 4096; v++) begin
            run_pair(32'(v), 8'(v), v < 16 ? "R1" : "R3");
            if (v == 0) check("R7 enc_valid", {31'd0, enc_valid_o}, 32'd1);
        end

        // R2: values around each bucket base
        for (int e = 1; e < 16; e++) begin
            run_pair(32'(base_of(e) - 1), 8'h00, "R2 below");
            check("R2 exp below", {28'd0, enc_code_o[7:4]}, 32'(e - 1));
            run_pair(32'(base_of(e)), 8'h00, "R2 at");
            check("R2 exp at", {28'd0, enc_code_o[7:4]}, 32'(e));
            run_pair(32'(base_of(e) + (longint'(1) << e)), 8'h00, "R3 step");
        end

        // R4: oversized inputs wrap the mantissa
        run_pair(32'h000F_FFFF, 8'h00, "R4");
        check("R4 fffff", {24'd0, enc_code_o}, 32'h0000_00F0);
        run_pair(32'h0012_3456, 8'h00, "R4");
        check("R4 123456", {24'd0, enc_code_o}, 32'h0000_00F4);
        run_pair(32'hFFFF_FFFF, 8'h00, "R4");
        check("R4 ffffffff", {24'd0, enc_code_o}, 32'h0000_00F0);
        run_pair(32'h0007_FFF0, 8'h00, "R4");
        check("R4 top base", {24'd0, enc_code_o}, 32'h0000_00F0);

        // R2/R3: pseudo-random spread of magnitudes
        for (int i = 0; i < 2000; i++) begin
            r = r ^ (r << 13);
            r = r ^ (r >> 17);
            r = r ^ (r << 5);
            run_pair(r >> r[4:0], 8'h00, "R3 rand");
        end

        // R5 and R6: every code byte, decoded value fed to the encoder
        for (int c = 0; c < 256; c++) begin
            run_pair(ref_dec(8'(c)), 8'(c), "R6");
            check("R5 dec", dec_value_o, ref_dec(8'(c)));
            check("R6 roundtrip", {24'd0, enc_code_o}, 32'(c));
        end

        // R8: idle cycles hold data, R7: valid tracks input one cycle later
        run_pair(32'd1000, 8'h5A, "R8 setup");
        held   = enc_code_o;
        held_v = dec_value_o;
        enc_valid_i = 1'b0;
        enc_value_i = 32'hDEAD_BEEF;
        dec_valid_i = 1'b0;
        dec_code_i  = 8'hFF;
        @(negedge clk);
        check("R8 enc hold", {24'd0, enc_code_o}, {24'd0, held});
        check("R8 dec hold", dec_value_o, held_v);
        check("R7 enc_valid low", {31'd0, enc_valid_o}, 32'd0);
        check("R7 dec_valid low", {31'd0, dec_valid_o}, 32'd0);
        // R7: paths independent
        dec_valid_i = 1'b1;
        dec_code_i  = 8'h31;
        @(negedge clk);
        check("R7 dec only valid", {31'd0, dec_valid_o}, 32'd1);
        check("R7 enc stays idle", {31'd0, enc_valid_o}, 32'd0);
        check("R7 enc untouched", {24'd0, enc_code_o}, {24'd0, held});
        check("R5 dec only", dec_value_o, ref_dec(8'h31));

        // R9: reset mid-run
        enc_valid_i = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check("R9 mid enc_valid", {31'd0, enc_valid_o}, 32'd0);
        check("R9 mid enc_code", {24'd0, enc_code_o}, 32'd0);
        check("R9 mid dec_valid", {31'd0, dec_valid_o}, 32'd0);
        check("R9 mid dec_value", dec_value_o, 32'd0);
        rst = 1'b0;
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule